// File: doc/BRIEF.md
# Packed 8x16 Rounding Multiplier

This block multiplies a 64-bit packed operand holding four signed 16-bit lanes by 8-bit values taken from a second 64-bit operand. Each product is 24 bits plus sign. In the narrow modes it is rounded and cut down to a 16-bit lane result. In the two widening modes only the two low lanes are computed, and each keeps its full rounded product in a 32-bit result lane.

A 3-bit mode input selects the operands. The 8-bit factor can be byte r of the low word of `src_a`, or the signed high byte or unsigned low byte of 16-bit lane r of `src_a`. The 16-bit factor can be lane r of `src_b` or one lane of `src_b` broadcast to every lane. Operands and mode are captured together with `in_valid`. The result appears two clock edges later, together with `out_valid`.

Top module: `pmul8x16_round`

## Requirements
- R1: While `rst` is high, and on the edge that samples it, `out_valid` goes to 0 and `result` to all zeros.
- R2: `out_valid` is high exactly two rising edges after an edge that sampled `in_valid` high, with no other delay.
- R3: When the edge two cycles earlier did not sample `in_valid` high, `result` keeps its previous value.
- R4: Mode 0: 16-bit lane r (bits 16r+15..16r) of the result is built from signed lane r of `src_b` times the unsigned byte at bits 8r+7..8r of `src_a`, for r = 0..3.
- R5: Mode 1: as mode 0, but every lane uses signed lane 1 of `src_b` (bits 31..16).
- R6: Mode 2: as mode 0, but every lane uses signed lane 0 of `src_b` (bits 15..0).
- R7: Mode 3: lane r uses signed lane r of `src_b` times the signed byte at bits 16r+15..16r+8 of `src_a`.
- R8: Mode 4: lane r uses signed lane r of `src_b` times the unsigned byte at bits 16r+7..16r of `src_a`.
- R9: Mode 5 (widening): for r = 0 and 1, the 32-bit result lane at bits 32r+31..32r holds the full rounded product of signed lane r of `src_b` and the signed byte at bits 16r+15..16r+8 of `src_a`. Each lane uses the operands as they were captured, so lane 1 is not disturbed by lane 0.
- R10: Mode 6 (widening): as mode 5, but the factor is the unsigned byte at bits 16r+7..16r of `src_a`.
- R11: Mode 7 is unused and yields an all-zero result.
- R12: Rounding works on the two's-complement product P. When bits 7..0 of P are 0x80 or more, 0x100 is added. A narrow lane result is bits 23..8 of the rounded value. Low byte 0x7F does not round up and low byte 0x80 does, for both positive and negative products.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| src_a | input | 64 | Source of the 8-bit factors |
| src_b | input | 64 | Four signed 16-bit lanes |
| mode | input | 3 | Operand selection and width mode, codes 0..7 |
| out_valid | output | 1 | Result valid, two edges after `in_valid` |
| result | output | 64 | Packed lane results |

## Verification
The bench builds the block with its defaults: four lanes of 16 bits, 8-bit factors, and broadcast lanes 1 and 0. With these values the extreme lanes 0x8000 and 0x7FFF, both signed-byte limits, and the rounding boundary at low byte 0x7F/0x80 are all reachable with directed vectors. Random vectors then cover all eight mode codes, with bubbles between them that exercise the hold and latency behaviour.

// File: rtl/pmr_pkg.sv
package pmr_pkg;

   typedef enum logic [2:0] {
      PM_LANE    = 3'd0,
      PM_BC_LO   = 3'd1,
      PM_BC_HI   = 3'd2,
      PM_UPPER   = 3'd3,
      PM_LOWER   = 3'd4,
      PM_WIDE_UP = 3'd5,
      PM_WIDE_LO = 3'd6,
      PM_NONE    = 3'd7
   } pmr_mode_e;

   function automatic logic pmr_is_wide(input pmr_mode_e m);
      return (m == PM_WIDE_UP) || (m == PM_WIDE_LO);
   endfunction

endpackage

// File: rtl/pmr_opsel.sv
module pmr_opsel
   import pmr_pkg::*;
#(
   parameter int LANES      = 4,
   parameter int LANE_W     = 16,
   parameter int BYTE_W     = 8,
   parameter int BC_LO_LANE = 1,
   parameter int BC_HI_LANE = 0
) (
   input  logic [LANES*LANE_W-1:0]     a_i,
   input  logic [LANES*LANE_W-1:0]     b_i,
   input  pmr_mode_e                   mode_i,
   output logic [LANES*LANE_W-1:0]     mcand_o,
   output logic [LANES*(BYTE_W+1)-1:0] mplier_o
);
   localparam int MW = BYTE_W + 1;

   if (BC_LO_LANE >= LANES || BC_HI_LANE >= LANES) begin : g_bad_bcast
      $error("pmr_opsel: broadcast lane index out of range");
   end

   for (genvar r = 0; r < LANES; r++) begin : g_lane
      logic [BYTE_W-1:0] word_byte;
      logic [BYTE_W-1:0] hi_byte;
      logic [BYTE_W-1:0] lo_byte;
      logic [LANE_W-1:0] mc;
      logic [MW-1:0]     mp;

      assign word_byte = a_i[r*BYTE_W +: BYTE_W];
      assign hi_byte   = a_i[r*LANE_W+BYTE_W +: BYTE_W];
      assign lo_byte   = a_i[r*LANE_W +: BYTE_W];

      always_comb begin
         mc = b_i[r*LANE_W +: LANE_W];
         mp = {1'b0, word_byte};
         unique case (mode_i)
            PM_LANE: ;
            PM_BC_LO: mc = b_i[BC_LO_LANE*LANE_W +: LANE_W];
            PM_BC_HI: mc = b_i[BC_HI_LANE*LANE_W +: LANE_W];
            PM_UPPER, PM_WIDE_UP: mp = {hi_byte[BYTE_W-1], hi_byte};
            PM_LOWER, PM_WIDE_LO: mp = {1'b0, lo_byte};
            default: begin
               mc = '0;
               mp = '0;
            end
         endcase
      end

      assign mcand_o[r*LANE_W +: LANE_W] = mc;
      assign mplier_o[r*MW +: MW]        = mp;
   end

endmodule

// File: rtl/pmr_lane.sv
module pmr_lane #(
   parameter int LANE_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic [LANE_W-1:0]   mcand_i,
   input  logic [BYTE_W:0]     mplier_i,
   output logic [LANE_W-1:0]   narrow_o,
   output logic [2*LANE_W-1:0] wide_o
);
   localparam int PW = LANE_W + BYTE_W + 1;
   localparam int WW = 2 * LANE_W;
   localparam logic [WW-1:0] RND_INC = WW'(1) << BYTE_W;

   if (WW <= PW) begin : g_bad_width
      $error("pmr_lane: lane too narrow for the product");
   end

   logic signed [PW-1:0] prod;
   logic [WW-1:0]        ext;
   logic [WW-1:0]        rnd;

   assign prod     = $signed(mcand_i) * $signed(mplier_i);
   assign ext      = {{(WW-PW){prod[PW-1]}}, prod};
   assign rnd      = ext + (ext[BYTE_W-1] ? RND_INC : '0);
   assign narrow_o = rnd[BYTE_W +: LANE_W];
   assign wide_o   = rnd;

endmodule

// File: rtl/pmr_pack.sv
module pmr_pack
   import pmr_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int LANE_W = 16
) (
   input  pmr_mode_e                     mode_i,
   input  logic [LANES*LANE_W-1:0]       narrow_i,
   input  logic [LANES*2*LANE_W-1:0]     wide_i,
   output logic [LANES*LANE_W-1:0]       res_o
);
   localparam int WW    = 2 * LANE_W;
   localparam int PAIRS = LANES / 2;

   if (LANES % 2 != 0) begin : g_bad_lanes
      $error("pmr_pack: lane count must be even");
   end

   logic wide_sel;
   assign wide_sel = pmr_is_wide(mode_i);

   for (genvar w = 0; w < PAIRS; w++) begin : g_pair
      assign res_o[w*WW +: WW] = wide_sel ? wide_i[w*WW +: WW]
                                          : narrow_i[w*WW +: WW];
   end

endmodule

// File: rtl/pmul8x16_round.sv
module pmul8x16_round
   import pmr_pkg::*;
#(
   parameter int LANES      = 4,
   parameter int LANE_W     = 16,
   parameter int BYTE_W     = 8,
   parameter int BC_LO_LANE = 1,
   parameter int BC_HI_LANE = 0
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    in_valid,
   input  logic [LANES*LANE_W-1:0] src_a,
   input  logic [LANES*LANE_W-1:0] src_b,
   input  logic [2:0]              mode,
   output logic                    out_valid,
   output logic [LANES*LANE_W-1:0] result
);
   localparam int DW = LANES * LANE_W;
   localparam int MW = BYTE_W + 1;
   localparam int WW = 2 * LANE_W;

   if (LANE_W != 2 * BYTE_W) begin : g_bad_ratio
      $error("pmul8x16_round: lane width must be twice the byte width");
   end

   // stage 1: capture
   logic            v1;
   logic [DW-1:0]   a_q;
   logic [DW-1:0]   b_q;
   pmr_mode_e       mode_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         v1     <= 1'b0;
         a_q    <= '0;
         b_q    <= '0;
         mode_q <= PM_LANE;
      end else begin
         v1 <= in_valid;
         if (in_valid) begin
            a_q    <= src_a;
            b_q    <= src_b;
            mode_q <= pmr_mode_e'(mode);
         end
      end
   end

   // operand selection, lane multipliers, packing
   logic [DW-1:0]       mcand;
   logic [LANES*MW-1:0] mplier;
   logic [DW-1:0]       narrow;
   logic [LANES*WW-1:0] wide;
   logic [DW-1:0]       res_c;

   pmr_opsel #(
      .LANES(LANES), .LANE_W(LANE_W), .BYTE_W(BYTE_W),
      .BC_LO_LANE(BC_LO_LANE), .BC_HI_LANE(BC_HI_LANE)
   ) u_sel (
      .a_i(a_q), .b_i(b_q), .mode_i(mode_q),
      .mcand_o(mcand), .mplier_o(mplier)
   );

   for (genvar r = 0; r < LANES; r++) begin : g_mul
      pmr_lane #(.LANE_W(LANE_W), .BYTE_W(BYTE_W)) u_lane (
         .mcand_i (mcand[r*LANE_W +: LANE_W]),
         .mplier_i(mplier[r*MW +: MW]),
         .narrow_o(narrow[r*LANE_W +: LANE_W]),
         .wide_o  (wide[r*WW +: WW])
      );
   end

   pmr_pack #(.LANES(LANES), .LANE_W(LANE_W)) u_pack (
      .mode_i(mode_q), .narrow_i(narrow), .wide_i(wide), .res_o(res_c)
   );

   // stage 2: result
   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= v1;
         if (v1) result <= res_c;
      end
   end

   // assertion support: edges seen since reset
   logic [1:0] warm;
   always_ff @(posedge clk) begin
      if (rst)              warm <= '0;
      else if (warm != 2'd2) warm <= warm + 2'd1;
   end

   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (!out_valid && result == '0));

   a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
      (warm == 2'd2) |-> (out_valid == $past(in_valid, 2)));

   a_r3_hold_result: assert property (@(posedge clk) disable iff (rst)
      (warm == 2'd2 && !$past(in_valid, 2)) |-> $stable(result));

   a_r11_unused_zero: assert property (@(posedge clk) disable iff (rst)
      (warm != 2'd0 && out_valid && $past(mode_q) == PM_NONE) |-> (result == '0));

endmodule

// File: tb/sim_pmul8x16_round.sv
`timescale 1ns/1ps
module sim_pmul8x16_round;

   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [63:0] src_a, src_b;
   logic [2:0]  mode;
   logic        out_valid;
   logic [63:0] result;

   always #2.5 clk = ~clk;

   pmul8x16_round u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid),
      .src_a(src_a), .src_b(src_b), .mode(mode),
      .out_valid(out_valid), .result(result)
   );

   int    n_vec  = 0;
   int    n_bad  = 0;
   bit    done   = 0;
   bit    corner = 0;

   // behavioural model state
   bit          s1v;
   logic [63:0] s1a, s1b, mres;
   logic [2:0]  s1m;
   bit          mv;
   string       mtag;

   function automatic logic [63:0] ref_calc(input logic [63:0] a, b, input logic [2:0] m);
      logic [63:0] res = '0;
      for (int r = 0; r < 4; r++) begin
         int bl, ml, p;
         logic [31:0] pu;
         bl = $signed(b[16*r +: 16]);
         ml = int'(a[8*r +: 8]);
         case (m)
            3'd1: bl = $signed(b[31:16]);
            3'd2: bl = $signed(b[15:0]);
            3'd3, 3'd5: ml = $signed(a[16*r+8 +: 8]);
            3'd4, 3'd6: ml = int'(a[16*r +: 8]);
            default: ;
         endcase
         p = bl * ml;
         if ((p & 255) > 127) p = p + 256;
         pu = p;
         if (m == 3'd7) res = '0;
         else if (m == 3'd5 || m == 3'd6) begin
            if (r < 2) res[32*r +: 32] = pu;
         end else res[16*r +: 16] = pu[23:8];
      end
      return res;
   endfunction

   function automatic string tag_of(input logic [2:0] m);
      case (m)
         3'd0: return "R4";
         3'd1: return "R5";
         3'd2: return "R6";
         3'd3: return "R7";
         3'd4: return "R8";
         3'd5: return "R9";
         3'd6: return "R10";
         default: return "R11";
      endcase
   endfunction

   task automatic step(input bit v, input logic [63:0] a, b, input logic [2:0] m);
      bit          nv;
      logic [63:0] nres;
      string       ntag;
      in_valid = v; src_a = a; src_b = b; mode = m;
      nv   = s1v;
      nres = s1v ? ref_calc(s1a, s1b, s1m) : mres;
      ntag = s1v ? (corner ? "R12" : tag_of(s1m)) : "R3";
      if (v) begin s1a = a; s1b = b; s1m = m; end
      s1v = v;
      mv = nv; mres = nres; mtag = ntag;
      @(negedge clk);
      n_vec++;
      if (out_valid !== mv || result !== mres) begin
         n_bad++;
         if (out_valid !== mv)
            $display("FAIL R2 out_valid actual %0b expected %0b", out_valid, mv);
         if (result !== mres)
            $display("FAIL %s result actual %h expected %h", mtag, result, mres);
      end
   endtask

   initial begin
      #1000000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual hung expected finish");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; in_valid = 1'b0; src_a = '0; src_b = '0; mode = '0;
      s1v = 0; s1a = '0; s1b = '0; s1m = '0; mres = '0; mv = 0; mtag = "R1";
      repeat (3) @(negedge clk);
      // R1: reset state
      n_vec++;
      if (out_valid !== 1'b0 || result !== 64'h0) begin
         n_bad++;
         $display("FAIL R1 actual %0b/%h expected 0/0", out_valid, result);
      end
      rst = 1'b0;

      // R12: rounding boundary, positive and negative products
      corner = 1;
      step(1, 64'h0000_0000_0101_0101, 64'h007F_0080_FFFF_FF81, 3'd0);
      step(1, 64'h0000_0000_8080_0101, 64'hFFFF_FFFF_0080_007F, 3'd0);
      step(0, '0, '0, 3'd0);
      step(0, '0, '0, 3'd0);
      corner = 0;

      // R4..R11: each mode with extreme and mixed operands
      for (int m = 0; m < 8; m++) begin
         step(1, 64'h80FF_7F01_FF80_7F00, 64'h8000_7FFF_1234_EDCC, 3'(m));
         step(1, 64'h0000_0000_FFFF_FFFF, 64'h8000_8000_8000_8000, 3'(m));
         step(1, 64'h7F80_01FE_C3A5_5A3C, 64'hFEDC_0123_7FFF_8001, 3'(m));
      end
      step(0, '0, '0, 3'd0);
      step(0, '0, '0, 3'd0);

      // R2 and R3: bubbles between valid inputs, data toggling while idle
      step(1, 64'h1111_2222_3333_4444, 64'h0102_0304_0506_0708, 3'd3);
      step(0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 3'd0);
      step(0, 64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 3'd1);
      step(1, 64'h0F0F_F0F0_0F0F_F0F0, 64'h8001_7FFE_4000_C000, 3'd5);
      step(0, '0, '0, 3'd6);
      step(0, '0, '0, 3'd6);

      for (int i = 0; i < 600; i++)
         step(($urandom % 4) != 0, {$urandom, $urandom}, {$urandom, $urandom}, 3'($urandom % 8));
      step(0, '0, '0, 3'd0);
      step(0, '0, '0, 3'd0);

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule